// File: doc/BRIEF.md
# SPI Display Frame Streamer

This block moves a complete greyscale framebuffer (two 4-bit pixels per byte) from on-chip memory to an OLED display controller over a write-only SPI link with a chip-select and a data/command select line. A one-cycle `frameStart` pulse sends three addressing commands: column window, row window and write-memory. It then streams every framebuffer byte inside a single chip-select window with the data/command line high. The framebuffer is read through a synchronous read port, one cycle of latency. The next byte is fetched while the current one is still shifting, so the serial clock runs without gaps inside a window.

A second entry, `cmdStart`, sends one arbitrary opcode followed by zero, one or two parameter bytes in a single chip-select window. This is used for any controller setting. The frame path has two pixel formats. In the normal format, buffer bytes go out unchanged. In the pixel-doubled format, each logical pixel drives two segment outputs, so each buffer byte becomes two bytes, and the column window is computed to match.

Both entries are ignored while `busy` is high. `done` marks the end of every transaction.

Top module: `spi_frame_streamer`

## Requirements
- R1: After reset `csN` is high, `sck` is low, and `busy` and `done` are low.
- R2: Signal levels and bit order:
  - SPI mode 0: `sck` idles low and `mosi`/`dc` are stable while `sck` is high.
  - Bytes go MSB first.
  - `csN` stays low for a whole window.
  - `dc` is low for an opcode byte and high for parameter and pixel bytes, and it is constant across the 8 bits of a byte.
- R3: A command window carries the opcode followed by `cmdParam0` and then `cmdParam1`, as selected by `cmdParamCount` (0, 1 or 2). A count of 3 is treated as 2.
- R4: A frame sends four chip-select windows in this order:
  - opcode `OP_COL` (default 0x15) with column start `xOffset` and the column end;
  - opcode `OP_ROW` (default 0x75) with `yOffset` and `HEIGHT-1`;
  - opcode `OP_WRITE` (default 0x5C) alone;
  - one data window.
- R5: In normal format (`pixDouble`=0), the data window carries framebuffer bytes 0 to `WIDTH*HEIGHT/2-1` in address order, and the column end is `xOffset + (WIDTH-1)/4` (modulo 256).
- R6: In pixel-doubled format (`pixDouble`=1), each buffer byte p is sent as `{p[7:4],p[7:4]}` followed by `{p[3:0],p[3:0]}`, and the column end is `xOffset + (WIDTH-1)/2`.
- R7: Inside a window, consecutive rising edges of `sck` are exactly `2*SCK_DIV` clock cycles apart. This holds across byte boundaries and through the data window.
- R8: `frameStart` and `cmdStart` have no effect while `busy` is high.
- R9: When `frameStart` and `cmdStart` are high in the same idle cycle, the frame runs and the command is dropped.
- R10: `done` is high for exactly one cycle, in the cycle after `csN` rises at the end of the last window of a transaction. `busy` is low from that cycle on.
- R11: Between two windows, `csN` stays high for at least `2*SCK_DIV` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Start a frame update (one-cycle pulse) |
| pixDouble | input | 1 | Pixel format for the frame: 1 = pixel-doubled |
| xOffset | input | 8 | Panel column offset |
| yOffset | input | 8 | Panel row offset |
| cmdStart | input | 1 | Start a generic command (one-cycle pulse) |
| cmdOpcode | input | 8 | Command opcode |
| cmdParamCount | input | 2 | Number of parameter bytes |
| cmdParam0 | input | 8 | First parameter byte |
| cmdParam1 | input | 8 | Second parameter byte |
| fbRdEn | output | 1 | Framebuffer read strobe |
| fbAddr | output | $clog2(WIDTH*HEIGHT/2) | Framebuffer byte address |
| fbRdData | input | 8 | Framebuffer read data, valid one cycle after `fbRdEn` |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI serial data |
| csN | output | 1 | Chip select, active low |
| dc | output | 1 | Data/command select: 0 = command |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | End-of-transaction pulse |

## Verification
The two entries can collide: `frameStart` and `cmdStart` may rise in the same idle cycle, and either can rise while the other's transaction is still running. The bench drives both in one cycle from idle. It then checks that the decoded windows match the four-window frame stream exactly, that exactly one `done` occurs, and that no further window appears for hundreds of cycles afterwards. It also pulses both starts in the middle of a running frame and applies the same stream check.

// File: rtl/frame_streamer_pkg.sv
package frame_streamer_pkg;

  // byte offered by the control to the shift datapath
  typedef struct packed {
    logic       load;
    logic [7:0] data;
    logic       dcHigh;
    logic       winLast;
  } dpReq_t;

  // status strobes from the datapath back to the control
  typedef struct packed {
    logic holdFree;
    logic winEnd;
  } dpStat_t;

  typedef enum logic [1:0] {CT_IDLE, CT_HDR, CT_DATA, CT_FLUSH} ctrlState_t;
  typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_WAIT, SH_GAP} shState_t;

endpackage

// File: rtl/frame_streamer_dp.sv
module frame_streamer_dp
  import frame_streamer_pkg::*;
#(
  parameter int SCK_DIV = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  dpReq_t  req,
  output dpStat_t stat,
  output logic    sck,
  output logic    mosi,
  output logic    csN,
  output logic    dc
);
  localparam int DCW = (SCK_DIV > 1) ? $clog2(SCK_DIV) : 1;
  localparam int GAP = 2 * SCK_DIV;
  localparam int GW  = $clog2(GAP + 1);
  localparam logic [DCW-1:0] DIV_LAST = DCW'(SCK_DIV - 1);
  localparam logic [GW-1:0]  GAP_LAST = GW'(GAP - 1);

  shState_t       st;
  logic [DCW-1:0] divCnt;
  logic [GW-1:0]  gapCnt;
  logic [2:0]     bitCnt;
  logic [7:0]     shReg;
  logic           curLast;
  logic           holdValid, holdDc, holdLast;
  logic [7:0]     holdByte;
  logic           winEnd;

  assign mosi          = shReg[7];
  assign stat.holdFree = !holdValid;
  assign stat.winEnd   = winEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st        <= SH_IDLE;
      divCnt    <= '0;
      gapCnt    <= '0;
      bitCnt    <= '0;
      shReg     <= '0;
      curLast   <= 1'b0;
      holdValid <= 1'b0;
      holdDc    <= 1'b0;
      holdLast  <= 1'b0;
      holdByte  <= '0;
      winEnd    <= 1'b0;
      sck       <= 1'b0;
      csN       <= 1'b1;
      dc        <= 1'b0;
    end else begin
      winEnd <= 1'b0;
      if (req.load) begin
        holdValid <= 1'b1;
        holdByte  <= req.data;
        holdDc    <= req.dcHigh;
        holdLast  <= req.winLast;
      end
      case (st)
        SH_IDLE: begin
          if (holdValid) begin
            csN       <= 1'b0;
            shReg     <= holdByte;
            dc        <= holdDc;
            curLast   <= holdLast;
            holdValid <= 1'b0;
            divCnt    <= '0;
            bitCnt    <= '0;
            st        <= SH_SHIFT;
          end
        end
        SH_SHIFT: begin
          if (divCnt == DIV_LAST) begin
            divCnt <= '0;
            if (!sck) begin
              sck <= 1'b1;
            end else begin
              sck <= 1'b0;
              if (bitCnt == 3'd7) begin
                if (curLast) begin
                  csN    <= 1'b1;
                  winEnd <= 1'b1;
                  gapCnt <= '0;
                  st     <= SH_GAP;
                end else if (holdValid) begin
                  shReg     <= holdByte;
                  dc        <= holdDc;
                  curLast   <= holdLast;
                  holdValid <= 1'b0;
                  bitCnt    <= '0;
                end else begin
                  st <= SH_WAIT;
                end
              end else begin
                bitCnt <= bitCnt + 3'd1;
                shReg  <= {shReg[6:0], 1'b0};
              end
            end
          end else begin
            divCnt <= divCnt + DCW'(1);
          end
        end
        SH_WAIT: begin
          if (holdValid) begin
            shReg     <= holdByte;
            dc        <= holdDc;
            curLast   <= holdLast;
            holdValid <= 1'b0;
            bitCnt    <= '0;
            divCnt    <= '0;
            st        <= SH_SHIFT;
          end
        end
        SH_GAP: begin
          if (gapCnt == GAP_LAST) st <= SH_IDLE;
          else gapCnt <= gapCnt + GW'(1);
        end
        default: st <= SH_IDLE;
      endcase
    end
  end

  AST_SCK_LOW_OUTSIDE: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck); // R2
  AST_DATA_HELD_HIGH_SCK: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> ($stable(mosi) && $stable(dc))); // R2
  AST_CS_MIN_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |=> csN); // R11

endmodule

// File: rtl/frame_streamer_ctrl.sv
module frame_streamer_ctrl
  import frame_streamer_pkg::*;
#(
  parameter int          WIDTH    = 256,
  parameter int          HEIGHT   = 64,
  parameter logic [7:0]  OP_COL   = 8'h15,
  parameter logic [7:0]  OP_ROW   = 8'h75,
  parameter logic [7:0]  OP_WRITE = 8'h5C,
  parameter int          NBYTES   = WIDTH * HEIGHT / 2,
  parameter int          AW       = $clog2(NBYTES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameStart,
  input  logic          pixDouble,
  input  logic [7:0]    xOffset,
  input  logic [7:0]    yOffset,
  input  logic          cmdStart,
  input  logic [7:0]    cmdOpcode,
  input  logic [1:0]    cmdParamCount,
  input  logic [7:0]    cmdParam0,
  input  logic [7:0]    cmdParam1,
  output logic          fbRdEn,
  output logic [AW-1:0] fbAddr,
  input  logic [7:0]    fbRdData,
  input  dpStat_t       stat,
  output dpReq_t        req,
  output logic          busy,
  output logic          done
);
  localparam logic [7:0]    SPAN_NORM = 8'((WIDTH - 1) / 4);
  localparam logic [7:0]    SPAN_DBL  = 8'((WIDTH - 1) / 2);
  localparam logic [7:0]    ROW_END   = 8'(HEIGHT - 1);
  localparam logic [AW-1:0] LAST_ADDR = AW'(NBYTES - 1);

  ctrlState_t    st;
  logic [2:0]    step;
  logic          isFrame, dbl;
  logic [7:0]    opc, par0, par1, xs, xe, ys;
  logic [1:0]    pcnt;
  logic [AW-1:0] rdAddr;
  logic          rdPend, rdLast, haveLow, lowLast;
  logic [3:0]    lowNib;
  logic [7:0]    hdrData;
  logic          hdrDc, hdrLast, hdrFinal;

  assign fbAddr = rdAddr;
  assign busy   = (st != CT_IDLE);

  // header byte for the current step
  always_comb begin
    hdrData = '0;
    hdrDc   = 1'b0;
    hdrLast = 1'b0;
    if (isFrame) begin
      case (step)
        3'd0: hdrData = OP_COL;
        3'd1: begin hdrData = xs; hdrDc = 1'b1; end
        3'd2: begin hdrData = xe; hdrDc = 1'b1; hdrLast = 1'b1; end
        3'd3: hdrData = OP_ROW;
        3'd4: begin hdrData = ys; hdrDc = 1'b1; end
        3'd5: begin hdrData = ROW_END; hdrDc = 1'b1; hdrLast = 1'b1; end
        default: begin hdrData = OP_WRITE; hdrLast = 1'b1; end
      endcase
    end else begin
      case (step)
        3'd0: begin hdrData = opc; hdrLast = (pcnt == 2'd0); end
        3'd1: begin hdrData = par0; hdrDc = 1'b1; hdrLast = (pcnt == 2'd1); end
        default: begin hdrData = par1; hdrDc = 1'b1; hdrLast = 1'b1; end
      endcase
    end
    hdrFinal = isFrame ? (step == 3'd6) : (step == {1'b0, pcnt});
  end

  always_comb begin
    req    = '0;
    fbRdEn = 1'b0;
    case (st)
      CT_HDR: begin
        if (stat.holdFree) begin
          req.load    = 1'b1;
          req.data    = hdrData;
          req.dcHigh  = hdrDc;
          req.winLast = hdrLast;
        end
      end
      CT_DATA: begin
        if (rdPend) begin
          req.load    = 1'b1;
          req.data    = dbl ? {2{fbRdData[7:4]}} : fbRdData;
          req.dcHigh  = 1'b1;
          req.winLast = !dbl && rdLast;
        end else if (haveLow) begin
          if (stat.holdFree) begin
            req.load    = 1'b1;
            req.data    = {2{lowNib}};
            req.dcHigh  = 1'b1;
            req.winLast = lowLast;
          end
        end else if (stat.holdFree) begin
          fbRdEn = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= CT_IDLE;
      step    <= '0;
      isFrame <= 1'b0;
      dbl     <= 1'b0;
      opc     <= '0;
      par0    <= '0;
      par1    <= '0;
      pcnt    <= '0;
      xs      <= '0;
      xe      <= '0;
      ys      <= '0;
      rdAddr  <= '0;
      rdPend  <= 1'b0;
      rdLast  <= 1'b0;
      haveLow <= 1'b0;
      lowLast <= 1'b0;
      lowNib  <= '0;
      done    <= 1'b0;
    end else begin
      done   <= 1'b0;
      rdPend <= 1'b0;
      case (st)
        CT_IDLE: begin
          if (frameStart) begin
            isFrame <= 1'b1;
            dbl     <= pixDouble;
            xs      <= xOffset;
            xe      <= xOffset + (pixDouble ? SPAN_DBL : SPAN_NORM);
            ys      <= yOffset;
            step    <= '0;
            rdAddr  <= '0;
            haveLow <= 1'b0;
            st      <= CT_HDR;
          end else if (cmdStart) begin
            isFrame <= 1'b0;
            opc     <= cmdOpcode;
            par0    <= cmdParam0;
            par1    <= cmdParam1;
            pcnt    <= (cmdParamCount == 2'd3) ? 2'd2 : cmdParamCount;
            step    <= '0;
            st      <= CT_HDR;
          end
        end
        CT_HDR: begin
          if (stat.holdFree) begin
            step <= step + 3'd1;
            if (hdrFinal) st <= isFrame ? CT_DATA : CT_FLUSH;
          end
        end
        CT_DATA: begin
          if (rdPend) begin
            if (dbl) begin
              haveLow <= 1'b1;
              lowNib  <= fbRdData[3:0];
              lowLast <= rdLast;
            end else if (rdLast) begin
              st <= CT_FLUSH;
            end
          end else if (haveLow) begin
            if (stat.holdFree) begin
              haveLow <= 1'b0;
              if (lowLast) st <= CT_FLUSH;
            end
          end else if (stat.holdFree) begin
            rdPend <= 1'b1;
            rdLast <= (rdAddr == LAST_ADDR);
            rdAddr <= rdAddr + AW'(1);
          end
        end
        CT_FLUSH: begin
          if (stat.winEnd && stat.holdFree) begin
            done <= 1'b1;
            st   <= CT_IDLE;
          end
        end
        default: st <= CT_IDLE;
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R10
  AST_LOAD_INTO_FREE: assert property (@(posedge clk) disable iff (!rstN)
    req.load |-> stat.holdFree); // R7
  AST_READ_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    fbRdEn |=> !fbRdEn); // R5

endmodule

// File: rtl/spi_frame_streamer.sv
module spi_frame_streamer
  import frame_streamer_pkg::*;
#(
  parameter int         WIDTH    = 256,
  parameter int         HEIGHT   = 64,
  parameter int         SCK_DIV  = 2,
  parameter logic [7:0] OP_COL   = 8'h15,
  parameter logic [7:0] OP_ROW   = 8'h75,
  parameter logic [7:0] OP_WRITE = 8'h5C,
  localparam int        NBYTES   = WIDTH * HEIGHT / 2,
  localparam int        AW       = $clog2(NBYTES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameStart,
  input  logic          pixDouble,
  input  logic [7:0]    xOffset,
  input  logic [7:0]    yOffset,
  input  logic          cmdStart,
  input  logic [7:0]    cmdOpcode,
  input  logic [1:0]    cmdParamCount,
  input  logic [7:0]    cmdParam0,
  input  logic [7:0]    cmdParam1,
  output logic          fbRdEn,
  output logic [AW-1:0] fbAddr,
  input  logic [7:0]    fbRdData,
  output logic          sck,
  output logic          mosi,
  output logic          csN,
  output logic          dc,
  output logic          busy,
  output logic          done
);
  dpReq_t  req;
  dpStat_t stat;

  frame_streamer_ctrl #(
    .WIDTH(WIDTH), .HEIGHT(HEIGHT), .OP_COL(OP_COL), .OP_ROW(OP_ROW),
    .OP_WRITE(OP_WRITE), .NBYTES(NBYTES), .AW(AW)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .pixDouble(pixDouble),
    .xOffset(xOffset), .yOffset(yOffset), .cmdStart(cmdStart),
    .cmdOpcode(cmdOpcode), .cmdParamCount(cmdParamCount),
    .cmdParam0(cmdParam0), .cmdParam1(cmdParam1), .fbRdEn(fbRdEn),
    .fbAddr(fbAddr), .fbRdData(fbRdData), .stat(stat), .req(req),
    .busy(busy), .done(done)
  );

  frame_streamer_dp #(.SCK_DIV(SCK_DIV)) uDp (
    .clk(clk), .rstN(rstN), .req(req), .stat(stat),
    .sck(sck), .mosi(mosi), .csN(csN), .dc(dc)
  );

endmodule

// File: tb/tb_spi_frame_streamer.sv
module tb_spi_frame_streamer;
  localparam int W = 16;
  localparam int H = 4;
  localparam int DIV = 2;
  localparam int NB = W * H / 2;
  localparam int AW = $clog2(NB);
  localparam int MAXB = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0, pixDouble = 1'b0, cmdStart = 1'b0;
  logic [7:0] xOffset = 8'd28, yOffset = 8'd0;
  logic [7:0] cmdOpcode = '0, cmdParam0 = '0, cmdParam1 = '0;
  logic [1:0] cmdParamCount = '0;
  logic fbRdEn;
  logic [AW-1:0] fbAddr;
  logic [7:0] fbRdData = '0;
  logic sck, mosi, csN, dc, busy, done;

  always #5 clk = ~clk;

  spi_frame_streamer #(.WIDTH(W), .HEIGHT(H), .SCK_DIV(DIV)) dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .pixDouble(pixDouble),
    .xOffset(xOffset), .yOffset(yOffset), .cmdStart(cmdStart),
    .cmdOpcode(cmdOpcode), .cmdParamCount(cmdParamCount),
    .cmdParam0(cmdParam0), .cmdParam1(cmdParam1), .fbRdEn(fbRdEn),
    .fbAddr(fbAddr), .fbRdData(fbRdData), .sck(sck), .mosi(mosi),
    .csN(csN), .dc(dc), .busy(busy), .done(done)
  );

  logic [7:0] fbMem [NB];
  always @(posedge clk) if (fbRdEn) fbRdData <= fbMem[fbAddr];

  int checks = 0, errors = 0;

  // ---------------- SPI monitor (samples at negedge) ----------------
  logic [7:0] capB [MAXB];
  logic       capDc [MAXB];
  int         capW [MAXB];
  int capN = 0, winIdx = 0, cyc = 0, csHighAt = 0, lastRise = 0, lastRiseWin = -1;
  int bitN = 0, gapErr = 0, csGapErr = 0, dcBad = 0, fragErr = 0, doneCnt = 0, doneBad = 0;
  logic [7:0] shIn = '0;
  logic byteDc = 1'b0, prevCs = 1'b1, prevSck = 1'b0, prevDone = 1'b0, csRosePrev = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (done) begin
        doneCnt++;
        if (!csRosePrev || prevDone || busy) doneBad++;
      end
      if (prevCs && !csN && (cyc - csHighAt) < 2 * DIV) csGapErr++;
      if (sck && !prevSck && !csN) begin
        if (lastRiseWin == winIdx && (cyc - lastRise) != 2 * DIV) gapErr++;
        lastRise = cyc;
        lastRiseWin = winIdx;
        if (bitN == 0) byteDc = dc;
        else if (dc != byteDc) dcBad++;
        shIn = {shIn[6:0], mosi};
        bitN++;
        if (bitN == 8) begin
          if (capN < MAXB) begin
            capB[capN] = shIn; capDc[capN] = byteDc; capW[capN] = winIdx;
          end
          capN++;
          bitN = 0;
        end
      end
      csRosePrev = csN && !prevCs;
      if (csN && !prevCs) begin
        winIdx++;
        csHighAt = cyc;
        if (bitN != 0) fragErr++;
        bitN = 0;
      end
    end
    prevCs = csN; prevSck = sck; prevDone = done;
  end

  // ---------------- expected stream ----------------
  logic [7:0] expB [MAXB];
  logic       expDc [MAXB];
  int         expW [MAXB];
  int expN = 0;

  function automatic logic [7:0] colEnd(input logic [7:0] xo, input logic dbl);
    return xo + (dbl ? 8'((W - 1) / 2) : 8'((W - 1) / 4));
  endfunction

  task automatic push(input logic [7:0] b, input logic d, input int w);
    expB[expN] = b; expDc[expN] = d; expW[expN] = w; expN++;
  endtask

  task automatic buildFrame(input logic dbl, input logic [7:0] xo, input logic [7:0] yo);
    expN = 0;
    push(8'h15, 1'b0, 0); push(xo, 1'b1, 0); push(colEnd(xo, dbl), 1'b1, 0);
    push(8'h75, 1'b0, 1); push(yo, 1'b1, 1); push(8'(H - 1), 1'b1, 1);
    push(8'h5C, 1'b0, 2);
    for (int i = 0; i < NB; i++) begin
      if (dbl) begin
        push({2{fbMem[i][7:4]}}, 1'b1, 3);
        push({2{fbMem[i][3:0]}}, 1'b1, 3);
      end else push(fbMem[i], 1'b1, 3);
    end
  endtask

  task automatic buildCmd(input logic [7:0] op, input int n, input logic [7:0] a, input logic [7:0] b);
    expN = 0;
    push(op, 1'b0, 0);
    if (n >= 1) push(a, 1'b1, 0);
    if (n >= 2) push(b, 1'b1, 0);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int base = 0, doneBase = 0;
  task automatic arm();
    capN = 0; base = winIdx; doneBase = doneCnt;
    gapErr = 0; csGapErr = 0; dcBad = 0; fragErr = 0; doneBad = 0;
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic compare(input string tag);
    chk(capN == expN, {tag, " byte count"}, capN, expN);
    for (int i = 0; i < expN && i < capN; i++) begin
      chk(capB[i] == expB[i], {tag, " byte"}, capB[i], expB[i]);
      chk(capDc[i] == expDc[i], "R2 dc level", capDc[i], expDc[i]);
      chk(capW[i] - base == expW[i], "R4 window index", capW[i] - base, expW[i]);
    end
    chk(winIdx - base == expW[expN-1] + 1, "R4 window count", winIdx - base, expW[expN-1] + 1);
    chk(gapErr == 0, "R7 sck spacing", gapErr, 0);
    chk(csGapErr == 0, "R11 cs high gap", csGapErr, 0);
    chk(dcBad == 0 && fragErr == 0, "R2 byte integrity", dcBad + fragErr, 0);
    chk(doneCnt - doneBase == 1, "R10 done count", doneCnt - doneBase, 1);
    chk(doneBad == 0, "R10 done timing", doneBad, 0);
  endtask

  task automatic runCmd(input logic [7:0] op, input logic [1:0] n, input logic [7:0] a, input logic [7:0] b);
    int eff;
    eff = (n == 2'd3) ? 2 : int'(n);
    buildCmd(op, eff, a, b);
    arm();
    cmdOpcode = op; cmdParamCount = n; cmdParam0 = a; cmdParam1 = b; cmdStart = 1'b1;
    @(negedge clk); cmdStart = 1'b0;
    waitDone();
    compare("R3 command");
  endtask

  task automatic runFrame(input logic dbl, input logic [7:0] xo, input logic [7:0] yo,
                          input bit both, input bit poke);
    for (int i = 0; i < NB; i++) fbMem[i] = 8'($urandom);
    buildFrame(dbl, xo, yo);
    arm();
    pixDouble = dbl; xOffset = xo; yOffset = yo; frameStart = 1'b1;
    if (both) begin cmdOpcode = 8'hAE; cmdParamCount = 2'd1; cmdStart = 1'b1; end
    @(negedge clk); frameStart = 1'b0; cmdStart = 1'b0;
    if (poke) begin
      repeat (300) @(negedge clk);
      frameStart = 1'b1; cmdStart = 1'b1; cmdOpcode = 8'hAF; pixDouble = !dbl;
      @(negedge clk); frameStart = 1'b0; cmdStart = 1'b0;
    end
    waitDone();
    compare(dbl ? "R6 doubled frame" : "R5 normal frame");
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    chk(csN == 1'b1 && sck == 1'b0, "R1 reset lines", {csN, sck}, 2'b10);
    chk(busy == 1'b0 && done == 1'b0, "R1 reset status", {busy, done}, 2'b00);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R3 directed counts, including 3 -> 2
    runCmd(8'hA5, 2'd0, 8'h00, 8'h00);
    runCmd(8'h81, 2'd1, 8'h7F, 8'h00);
    runCmd(8'h15, 2'd2, 8'h1C, 8'h5B);
    runCmd(8'hC1, 2'd3, 8'h3C, 8'hE4);
    // R3 random commands
    for (int k = 0; k < 6; k++)
      runCmd(8'($urandom), 2'($urandom), 8'($urandom), 8'($urandom));

    // R4/R5 normal frame, typical offsets
    runFrame(1'b0, 8'd28, 8'd0, 1'b0, 1'b0);
    // R6 doubled frame
    runFrame(1'b1, 8'd28, 8'd0, 1'b0, 1'b0);
    // R5 column end wraps modulo 256
    runFrame(1'b0, 8'd254, 8'd9, 1'b0, 1'b0);
    // R8 starts during busy are ignored
    runFrame(1'b1, 8'd3, 8'd1, 1'b0, 1'b1);
    // R9 simultaneous starts: frame wins, command dropped
    runFrame(1'b0, 8'd28, 8'd0, 1'b1, 1'b0);
    base = winIdx;
    repeat (400) @(negedge clk);
    chk(winIdx == base && !busy, "R9 no stray window", winIdx - base, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule